// File: doc/BRIEF.md
# Indirect Addressing Register Unit

This block sits between the instruction decoder of a small 8-bit processor and its data RAM. Each instruction carries only a 4-bit data address, so on its own it can reach sixteen bytes. The unit widens that field into a 16-bit RAM address. A few short field values are reserved as indirect ports. An access through one of them goes to the address held in a pointer pair made of a high byte and a low byte. Every other field value goes to RAM directly, with the upper address bits at zero.

The pointer bytes are write-only latches that sit in the short address space just above the indirect ports. A write to one of those addresses loads the matching pointer byte. The same write still goes on to RAM at that short address, so a later read of that address returns the RAM copy. Writes made through an indirect port never touch the pointers, even when the pointer value selects one of the pointer addresses.

Requests come in on a valid/ready interface and leave on another valid/ready interface toward RAM. The unit passes both without buffering. It raises `mem_valid` in the same cycle as `req_valid` and drives `req_ready` straight from `mem_ready`. When the RAM holds `mem_ready` low, the requester must keep `req_valid` high and its fields stable. The request counts as accepted only on a clock edge where both valid and ready are high, and the pointers change only on such an edge.

Top module: `iau_top`

## Requirements
- R1: After a synchronous active-high reset, every pointer byte reads as 0x00, so field 0 and field 1 both map to address 0x0000.
- R2: Field values 2 through 15 map to RAM address {12'h000, field}. Fields 4 through 7 map this way for both reads and writes.
- R3: Field 0 maps to the address {pair-0 high byte, pair-0 low byte}.
- R4: Field 1 maps to the address {pair-1 high byte, pair-1 low byte}.
- R5: An accepted write to field 4 loads the pair-0 low byte, and field 5 loads the pair-0 high byte. Field 6 loads the pair-1 low byte, and field 7 loads the pair-1 high byte. The loaded value is `req_wdata`.
- R6: Every accepted write, including one to fields 4 through 7, reaches RAM with `mem_write` high and `mem_wdata` equal to `req_wdata`.
- R7: A pointer byte loaded on one clock edge is already in use for the effective address in the very next cycle.
- R8: A write through field 0 or field 1 leaves all pointer bytes unchanged, even when its effective address is 0x0004 to 0x0007.
- R9: `mem_valid` follows `req_valid`, and `req_ready` follows `mem_ready`. A write held off by a low `mem_ready` loads no pointer.
- R10: A read of fields 4 through 7 leaves every pointer byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_field | input | 4 | Short address field from the instruction |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| mem_valid | output | 1 | RAM access present |
| mem_ready | input | 1 | RAM accepts the access |
| mem_addr | output | 16 | Effective RAM address |
| mem_write | output | 1 | RAM write enable |
| mem_wdata | output | 8 | RAM write data |

## Verification
The address, write enable and data toward RAM are combinational. They are due in the same cycle as the request, so the monitor samples them one nanosecond after the falling edge on which the driver presents each access. A pointer load becomes visible one clock edge after the accepted write. The driver updates its reference pointer model only after it has queued the expected item for that write, so the item for the next access already uses the new value. The stall case is checked in the stalled cycle itself: the bench confirms that `req_ready` is low. It then confirms at the RAM port, on a later read through the indirect port, that the pointer did not change.

// File: rtl/iau_pkg.sv
package iau_pkg;

  // How a short address field is interpreted
  typedef enum logic [1:0] {
    KIND_DIRECT   = 2'd0,
    KIND_INDIRECT = 2'd1,
    KIND_POINTER  = 2'd2
  } kind_e;

endpackage

// File: rtl/iau_decode.sv
module iau_decode
  import iau_pkg::*;
#(
  parameter int FIELD_W  = 4,
  parameter int PAIRS    = 2,
  parameter int PTR_BASE = 4,
  localparam int IDX_W   = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic [FIELD_W-1:0] field_i,
  output kind_e              kind_o,
  output logic [IDX_W-1:0]   pair_o,
  output logic               is_hi_o
);

  localparam logic [FIELD_W-1:0] PORT_END = FIELD_W'(PAIRS);
  localparam logic [FIELD_W-1:0] WIN_LO   = FIELD_W'(PTR_BASE);
  localparam logic [FIELD_W-1:0] WIN_END  = FIELD_W'(PTR_BASE + 2 * PAIRS);

  logic [FIELD_W-1:0] off;

  always_comb begin
    off     = field_i - WIN_LO;
    kind_o  = KIND_DIRECT;
    pair_o  = '0;
    is_hi_o = 1'b0;
    if (field_i < PORT_END) begin
      kind_o = KIND_INDIRECT;
      pair_o = IDX_W'(field_i);
    end else if (field_i >= WIN_LO && field_i < WIN_END) begin
      kind_o  = KIND_POINTER;
      pair_o  = IDX_W'(off >> 1);
      is_hi_o = off[0];
    end
  end

endmodule

// File: rtl/iau_ptr_bank.sv
module iau_ptr_bank #(
  parameter int DATA_W = 8,
  parameter int PAIRS  = 2,
  localparam int IDX_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           ld_en_i,
  input  logic [IDX_W-1:0]               ld_pair_i,
  input  logic                           ld_hi_i,
  input  logic [DATA_W-1:0]              ld_data_i,
  output logic [PAIRS-1:0][ADDR_W-1:0]   ptr_o
);

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    logic [DATA_W-1:0] lo_q, hi_q;
    logic              sel;

    assign sel = ld_en_i && (ld_pair_i == IDX_W'(k));

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (sel) begin
        if (ld_hi_i) hi_q <= ld_data_i;
        else         lo_q <= ld_data_i;
      end
    end

    assign ptr_o[k] = {hi_q, lo_q};

    assert_ptr_reset_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (lo_q == '0 && hi_q == '0));

    assert_ptr_load_lo_R5: assert property (@(posedge clk) disable iff (rst)
      (ld_en_i && ld_pair_i == IDX_W'(k) && !ld_hi_i) |=> lo_q == $past(ld_data_i));

    assert_ptr_load_hi_R5: assert property (@(posedge clk) disable iff (rst)
      (ld_en_i && ld_pair_i == IDX_W'(k) && ld_hi_i) |=> hi_q == $past(ld_data_i));
  end

endmodule

// File: rtl/iau_addr_map.sv
module iau_addr_map
  import iau_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int DATA_W  = 8,
  parameter int PAIRS   = 2,
  localparam int IDX_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  kind_e                          kind_i,
  input  logic [IDX_W-1:0]               pair_i,
  input  logic [FIELD_W-1:0]             field_i,
  input  logic [PAIRS-1:0][ADDR_W-1:0]   ptr_i,
  output logic [ADDR_W-1:0]              addr_o
);

  always_comb begin
    if (kind_i == KIND_INDIRECT) addr_o = ptr_i[pair_i];
    else                         addr_o = {{(ADDR_W-FIELD_W){1'b0}}, field_i};
  end

endmodule

// File: rtl/iau_top.sv
module iau_top
  import iau_pkg::*;
#(
  parameter int FIELD_W  = 4,
  parameter int DATA_W   = 8,
  parameter int PAIRS    = 2,
  parameter int PTR_BASE = 4,
  localparam int IDX_W   = (PAIRS > 1) ? $clog2(PAIRS) : 1,
  localparam int ADDR_W  = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [FIELD_W-1:0] req_field,
  input  logic               req_write,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_write,
  output logic [DATA_W-1:0]  mem_wdata
);

  localparam logic [FIELD_W-1:0] WIN_LO = FIELD_W'(PTR_BASE);
  localparam logic [FIELD_W-1:0] WIN_HI = FIELD_W'(PTR_BASE + 2 * PAIRS - 1);
  localparam logic [FIELD_W-1:0] PORT_END = FIELD_W'(PAIRS);

  kind_e                        kind;
  logic [IDX_W-1:0]             pair;
  logic                         is_hi;
  logic                         fire;
  logic                         ld_en;
  logic [PAIRS-1:0][ADDR_W-1:0] ptr;

  iau_decode #(.FIELD_W(FIELD_W), .PAIRS(PAIRS), .PTR_BASE(PTR_BASE)) u_decode (
    .field_i (req_field),
    .kind_o  (kind),
    .pair_o  (pair),
    .is_hi_o (is_hi)
  );

  assign fire  = req_valid && mem_ready;
  assign ld_en = fire && req_write && (kind == KIND_POINTER);

  iau_ptr_bank #(.DATA_W(DATA_W), .PAIRS(PAIRS)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .ld_en_i   (ld_en),
    .ld_pair_i (pair),
    .ld_hi_i   (is_hi),
    .ld_data_i (req_wdata),
    .ptr_o     (ptr)
  );

  iau_addr_map #(.FIELD_W(FIELD_W), .DATA_W(DATA_W), .PAIRS(PAIRS)) u_map (
    .kind_i  (kind),
    .pair_i  (pair),
    .field_i (req_field),
    .ptr_i   (ptr),
    .addr_o  (mem_addr)
  );

  // Pass-through handshake: no storage at either edge
  assign mem_valid = req_valid;
  assign req_ready = mem_ready;
  assign mem_write = req_valid && req_write;
  assign mem_wdata = req_wdata;

  // Indirect ports: field k uses pair k (k=0 covers R3, k=1 covers R4)
  for (genvar k = 0; k < PAIRS; k++) begin : g_chk
    assert_indirect_map_R3: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_field == FIELD_W'(k)) |-> mem_addr == ptr[k]);
  end

  assert_direct_map_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_field >= PORT_END) |->
      (mem_addr[ADDR_W-1:FIELD_W] == '0 && mem_addr[FIELD_W-1:0] == req_field));

  // Only an accepted write into the pointer window may change a pointer (R9, R10)
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(fire && req_write && req_field >= WIN_LO && req_field <= WIN_HI) |=> $stable(ptr));

  assert_write_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (fire && req_write && req_field >= WIN_LO && req_field <= WIN_HI) |->
      (mem_write && mem_addr == ADDR_W'(req_field)));

endmodule

// File: tb/tb_iau_top.sv
`timescale 1ns/100ps
module tb_iau_top;

  typedef struct {
    logic [15:0] addr;
    logic        we;
    logic [7:0]  wdata;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_field = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [15:0] mem_addr;
  logic        mem_write;
  logic [7:0]  mem_wdata;

  int checks = 0;
  int fails  = 0;
  item_t q[$];
  logic [7:0] m_lo[2];
  logic [7:0] m_hi[2];

  always #2.5 clk = ~clk;

  iau_top dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_field(req_field), .req_write(req_write), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_write(mem_write), .mem_wdata(mem_wdata)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 2; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
  endtask

  // Driver: one accepted access per cycle, expected item pushed first
  task automatic access(input logic [3:0] f, input bit w, input logic [7:0] d, input string tag);
    item_t it;
    @(negedge clk);
    req_valid = 1'b1; req_field = f; req_write = w; req_wdata = d; mem_ready = 1'b1;
    it.addr  = (f < 4'd2) ? {m_hi[f[0]], m_lo[f[0]]} : {12'h000, f};
    it.we    = w;
    it.wdata = d;
    it.tag   = tag;
    q.push_back(it);
    if (w && f >= 4'd4 && f <= 4'd7) begin
      if (f[0]) m_hi[f[1]] = d;
      else      m_lo[f[1]] = d;
    end
  endtask

  task automatic stalled_write(input logic [3:0] f, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_field = f; req_write = 1'b1; req_wdata = d; mem_ready = 1'b0;
    #1;
    check(req_ready == 1'b0, "R9", "req_ready in stall", {15'b0, req_ready}, 16'h0);
    check(mem_valid == 1'b1, "R9", "mem_valid in stall", {15'b0, mem_valid}, 16'h1);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; mem_ready = 1'b1;
  endtask

  // Monitor: compares every accepted RAM access with the queue head
  initial begin
    forever begin
      @(negedge clk); #1;
      if (!rst && mem_valid && mem_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R9", "unexpected access", mem_addr, 16'h0);
        end else begin
          item_t e;
          e = q.pop_front();
          check(mem_addr == e.addr, e.tag, "mem_addr", mem_addr, e.addr);
          check(mem_write == e.we, e.tag, "mem_write", {15'b0, mem_write}, {15'b0, e.we});
          if (e.we)
            check(mem_wdata == e.wdata, e.tag, "mem_wdata", {8'h0, mem_wdata}, {8'h0, e.wdata});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1: pointers at zero after reset
    access(4'd0, 1'b0, 8'h00, "R1");
    access(4'd1, 1'b0, 8'h00, "R1");
    // R2: direct fields
    access(4'd2, 1'b0, 8'h00, "R2");
    access(4'd3, 1'b1, 8'h5A, "R2");
    for (int f = 8; f < 16; f++) access(4'(f), f[0], 8'(f * 3), "R2");
    // R5/R6: pointer writes pass to RAM; R7: used next cycle; R3
    access(4'd4, 1'b1, 8'h34, "R5_R6");
    access(4'd5, 1'b1, 8'h12, "R5_R6");
    access(4'd0, 1'b0, 8'h00, "R7_R3");
    // R4: pair 1
    access(4'd6, 1'b1, 8'hCD, "R5_R6");
    access(4'd7, 1'b1, 8'hAB, "R5_R6");
    access(4'd1, 1'b1, 8'h11, "R4");
    access(4'd4, 1'b1, 8'hFF, "R5");
    access(4'd0, 1'b0, 8'h00, "R7");
    // R8: indirect write aimed at a pointer address
    access(4'd5, 1'b1, 8'h00, "R5");
    access(4'd4, 1'b1, 8'h05, "R5");
    access(4'd0, 1'b1, 8'h77, "R8");
    access(4'd0, 1'b0, 8'h00, "R8");
    access(4'd1, 1'b0, 8'h00, "R8");
    // R10: reads of the pointer window load nothing
    access(4'd4, 1'b0, 8'h99, "R10");
    access(4'd7, 1'b0, 8'h99, "R10");
    access(4'd0, 1'b0, 8'h00, "R10");
    access(4'd1, 1'b0, 8'h00, "R10");
    // R9: stalled write loads nothing
    stalled_write(4'd5, 8'hEE);
    access(4'd0, 1'b0, 8'h00, "R9");
    idle();
    access(4'd2, 1'b0, 8'h00, "R9");
    // R1: reset again clears loaded pointers
    do_reset();
    access(4'd0, 1'b0, 8'h00, "R1");
    access(4'd1, 1'b0, 8'h00, "R1");
    idle();
    idle();
    check(q.size() == 0, "R9", "queue drained", 16'(q.size()), 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule